// File: doc/BRIEF.md
# I2S Stereo Sample Interleaver

This block moves 16-bit stereo audio over a two-slot I2S serial line. It uses a bit clock and a frame sync that come from outside. The block sees the bit clock as a one-cycle enable strobe in its own clock domain. On the transmit side, 32-bit sample pairs are loaded into a holding register. Each pair is split into two serial words: the low half goes in slot 0 and the high half in slot 1. On the receive side, two consecutive serial words are packed into one 32-bit pair: the slot-0 word fills the low half and the slot-1 word fills the high half. The pair is then offered to a sink. Transmit and receive share one bit strobe and one frame sync. One stereo frame therefore carries one pair in each direction, so a converter scan that runs at half this rate consumes two pairs per scan.

A start pulse runs an alignment sequence so that the transmit and receive slots enter normal operation in phase. The block waits for the next frame start and sends two zero words, one in each slot of that frame. It does not deliver the words received during that frame. Data starts with the following frame.

The control is a five-state machine:
- IDLE sends zeros until `start` arrives, then moves to ARM.
- ARM waits for a frame-start tick, sends zero in slot 0, and moves to FILL0.
- FILL0 sends zero at the slot-1 boundary and moves to FILL1.
- FILL1 fetches the first pair at the next slot-0 boundary and moves to RUN.
- RUN stays in place and alternates low half and high half.

Top module: `i2s_interleaver`

## Requirements
- R1: After reset, `sd_out` is 0, `rx_valid` is 0, `underrun` and `overrun` are 0, and `tx_room` is 1.
- R2: A tick is a clock cycle with `bit_en` high. A tick with `frame_sync` high is bit 0 of slot 0, and slot 1 starts 16 ticks later. Each word goes out MSB first, and `sd_out` presents the bit for a tick from the clock edge of that tick onward.
- R3: Before `start`, every transmitted word is zero, even when a pair is waiting in the holding register.
- R4: After `start`, both slots of the next frame that begins carry zero words. Data transmission begins with the frame after it.
- R5: At each data slot-0 boundary, the held pair is taken, its bits [15:0] are sent in slot 0 and its bits [31:16] in slot 1, and `tx_room` returns to 1. Asserting `tx_load` fills the register and drops `tx_room`.
- R6: Received words from the alignment frame are never delivered. In data frames, the slot-0 word becomes `rx_pair[15:0]` and the slot-1 word becomes `rx_pair[31:16]`. `rx_valid` rises on the last bit tick of slot 1 and falls after a cycle with `rx_take` high.
- R7: If the holding register is empty at a data slot-0 boundary, both slots of that frame send zero and `underrun` sets and stays set until reset.
- R8: If a pair completes while `rx_valid` is high and `rx_take` is low, the new pair replaces the old one and `overrun` sets and stays set until reset.
- R9: If `rx_take` is high in the same cycle that a pair completes, the new pair is presented with `rx_valid` high and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that begins the alignment sequence |
| bit_en | input | 1 | One-cycle strobe for each bit-clock rising edge |
| frame_sync | input | 1 | High on the tick that carries bit 0 of slot 0 |
| sd_in | input | 1 | Serial receive data, sampled on ticks |
| sd_out | output | 1 | Serial transmit data |
| tx_load | input | 1 | Writes `tx_data` into the holding register |
| tx_data | input | 32 | Outgoing sample pair, low half first |
| tx_room | output | 1 | Holding register is empty |
| rx_take | input | 1 | Sink accepts `rx_pair` |
| rx_pair | output | 32 | Received sample pair |
| rx_valid | output | 1 | `rx_pair` holds a pair that has not been taken |
| underrun | output | 1 | Sticky: a slot-0 boundary found no pair |
| overrun | output | 1 | Sticky: a received pair was overwritten |

## Verification
The sink's acceptance and the completion of a new received pair can fall in the same clock cycle. One pair is left pending. The bench then raises `rx_take` exactly for the cycle that holds the last bit tick of slot 1. The outcome passes if the pending pair is the one logged, `rx_valid` stays high with the freshly completed pair, and `overrun` stays low. The later overrun scenario covers the same completion with no take.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
    localparam int SLOT_W = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_FILL0,
        ST_FILL1,
        ST_RUN
    } ilv_state_t;
endpackage

// File: rtl/ilv_slot_timer.sv
module ilv_slot_timer #(
    parameter int WORD_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic frame_sync,
    output logic slot_first,
    output logic slot_last,
    output logic slot_idx
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam int POS_W = BIT_W + ilv_pkg::SLOT_W;

    logic [POS_W-1:0] cnt;
    logic [POS_W-1:0] pos;

    assign pos        = frame_sync ? '0 : cnt;
    assign slot_first = bit_en && (pos[BIT_W-1:0] == '0);
    assign slot_last  = bit_en && (pos[BIT_W-1:0] == '1);
    assign slot_idx   = pos[POS_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (bit_en)
            cnt <= pos + 1'b1;
    end
endmodule

// File: rtl/ilv_tx_shifter.sv
module ilv_tx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              sd
);
    logic [WORD_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
            sd <= 1'b0;
        end else if (load) begin
            sd <= word[WORD_W-1];
            sh <= {word[WORD_W-2:0], 1'b0};
        end else if (bit_en) begin
            sd <= sh[WORD_W-1];
            sh <= {sh[WORD_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/ilv_rx_shifter.sv
module ilv_rx_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              sd,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-2:0] sh;

    assign word = {sh, sd};

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh <= '0;
        else if (bit_en)
            sh <= word[WORD_W-2:0];
    end
endmodule

// File: rtl/i2s_interleaver.sv
module i2s_interleaver #(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                bit_en,
    input  logic                frame_sync,
    input  logic                sd_in,
    output logic                sd_out,
    input  logic                tx_load,
    input  logic [2*WORD_W-1:0] tx_data,
    output logic                tx_room,
    input  logic                rx_take,
    output logic [2*WORD_W-1:0] rx_pair,
    output logic                rx_valid,
    output logic                underrun,
    output logic                overrun
);
    import ilv_pkg::*;

    localparam int PAIR_W = 2 * WORD_W;

    ilv_state_t state, state_nx;

    logic              slot_first, slot_last, slot_idx;
    logic [WORD_W-1:0] tx_word, rx_word, rx_lo, hi_keep;
    logic [PAIR_W-1:0] hold;
    logic              hold_full;
    logic              take_lo, send_hi, capture;

    ilv_slot_timer #(.WORD_W(WORD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
        .slot_first(slot_first), .slot_last(slot_last), .slot_idx(slot_idx)
    );

    ilv_tx_shifter #(.WORD_W(WORD_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .load(slot_first),
        .word(tx_word), .sd(sd_out)
    );

    ilv_rx_shifter #(.WORD_W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sd(sd_in), .word(rx_word)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ARM;
            ST_ARM:   if (slot_first && !slot_idx) state_nx = ST_FILL0;
            ST_FILL0: if (slot_first && slot_idx) state_nx = ST_FILL1;
            ST_FILL1: if (slot_first && !slot_idx) state_nx = ST_RUN;
            ST_RUN:   state_nx = ST_RUN;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // outputs: slot word selection and capture strobes
    always_comb begin
        take_lo = slot_first && !slot_idx && (state == ST_FILL1 || state == ST_RUN);
        send_hi = slot_first && slot_idx && (state == ST_RUN);
        capture = slot_last && (state == ST_RUN);
        if (take_lo)
            tx_word = hold_full ? hold[WORD_W-1:0] : '0;
        else if (send_hi)
            tx_word = hi_keep;
        else
            tx_word = '0;
    end

    assign tx_room = !hold_full;

    // transmit holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            hold_full <= 1'b0;
            hi_keep   <= '0;
            underrun  <= 1'b0;
        end else begin
            if (tx_load)
                hold <= tx_data;
            if (tx_load)
                hold_full <= 1'b1;
            else if (take_lo)
                hold_full <= 1'b0;
            if (take_lo) begin
                hi_keep <= hold_full ? hold[PAIR_W-1:WORD_W] : '0;
                if (!hold_full)
                    underrun <= 1'b1;
            end
        end
    end

    // receive packing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_lo    <= '0;
            rx_pair  <= '0;
            rx_valid <= 1'b0;
            overrun  <= 1'b0;
        end else begin
            if (capture && !slot_idx)
                rx_lo <= rx_word;
            if (capture && slot_idx) begin
                rx_pair  <= {rx_word, rx_lo};
                rx_valid <= 1'b1;
                if (rx_valid && !rx_take)
                    overrun <= 1'b1;
            end else if (rx_take) begin
                rx_valid <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ilv_checker.sv
module ilv_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic sd_out,
    input logic tx_load,
    input logic tx_room,
    input logic rx_take,
    input logic rx_valid,
    input logic underrun,
    input logic overrun
);
    a_r2_sd_holds_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_en) |-> $stable(sd_out));

    a_r5_room_falls_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_room) |-> $past(tx_load));

    a_r6_valid_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(bit_en));

    a_r7_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> underrun);

    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r8_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $past(rx_valid && !rx_take && bit_en));
endmodule

bind i2s_interleaver ilv_checker u_chk (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sd_out(sd_out),
    .tx_load(tx_load), .tx_room(tx_room), .rx_take(rx_take),
    .rx_valid(rx_valid), .underrun(underrun), .overrun(overrun)
);

// File: tb/tb_i2s_interleaver.sv
module tb_i2s_interleaver;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, bit_en = 1'b0, frame_sync = 1'b0, sd_in = 1'b0;
    logic tx_load = 1'b0, rx_take = 1'b0;
    logic [31:0] tx_data = '0;
    logic sd_out, tx_room, rx_valid, underrun, overrun;
    logic [31:0] rx_pair;

    i2s_interleaver dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
        .frame_sync(frame_sync), .sd_in(sd_in), .sd_out(sd_out),
        .tx_load(tx_load), .tx_data(tx_data), .tx_room(tx_room),
        .rx_take(rx_take), .rx_pair(rx_pair), .rx_valid(rx_valid),
        .underrun(underrun), .overrun(overrun)
    );

    always #5 clk = ~clk;

    int checks = 0, errors = 0;
    int p = 0, frame_no = 0, log_cnt = 0;
    logic [15:0] tx_log [256];
    logic [31:0] rx_log [64];
    int rx_n = 0, feed_n = 0;
    bit feed_en = 0, run_serial = 0, coinc_done = 0;
    int take_mode = 1;

    function automatic logic [15:0] in_word(int g);
        logic [31:0] gg;
        gg = g;
        return {8'hA5 ^ gg[7:0], gg[7:0]};
    endfunction

    function automatic logic [31:0] pair_val(int n);
        logic [31:0] nn;
        nn = n;
        return {16'hC3A0 + nn[15:0], 16'h1E00 + nn[15:0]};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick_wait();
        @(posedge clk); #1;
    endtask

    task automatic wait_logged(input int g);
        while (log_cnt <= g) tick_wait();
    endtask

    // serial line model: a tick every two clocks, frame of 32 ticks
    initial begin
        logic [15:0] shw, w;
        int g;
        shw = '0;
        wait (run_serial);
        forever begin
            @(negedge clk);
            g = frame_no * 2 + p / 16;
            w = in_word(g);
            bit_en = 1'b1;
            frame_sync = (p == 0);
            sd_in = w[15 - (p % 16)];
            @(negedge clk);
            bit_en = 1'b0;
            frame_sync = 1'b0;
            shw = {shw[14:0], sd_out};
            if (p % 16 == 15) begin
                if (g < 256) tx_log[g] = shw;
                log_cnt = g + 1;
            end
            p = p + 1;
            if (p == 32) begin
                p = 0;
                frame_no = frame_no + 1;
            end
        end
    end

    // pair source
    initial begin
        forever begin
            @(negedge clk);
            if (tx_load) tx_load = 1'b0;
            else if (feed_en && tx_room) begin
                tx_data = pair_val(feed_n);
                feed_n = feed_n + 1;
                tx_load = 1'b1;
            end
        end
    end

    // pair sink
    initial begin
        forever begin
            tick_wait();
            if ((take_mode == 1 && rx_valid) ||
                (take_mode == 2 && rx_valid && p == 31 && !bit_en)) begin
                if (rx_n < 64) rx_log[rx_n] = rx_pair;
                rx_n = rx_n + 1;
                if (take_mode == 2) begin
                    take_mode = 0;
                    coinc_done = 1;
                end
                @(negedge clk) rx_take = 1'b1;
                @(negedge clk) rx_take = 1'b0;
            end
        end
    end

    task automatic t_reset();
        tick_wait();
        chk({31'b0, sd_out}, 32'd0, "R1 sd_out");
        chk({31'b0, rx_valid}, 32'd0, "R1 rx_valid");
        chk({30'b0, underrun, overrun}, 32'd0, "R1 flags");
        chk({31'b0, tx_room}, 32'd1, "R1 tx_room");
    endtask

    task automatic t_idle();
        feed_en = 1;
        wait_logged(1);
        chk({31'b0, tx_room}, 32'd0, "R5 room drops after load");
        chk({16'b0, tx_log[0]}, 32'd0, "R3 idle slot0");
        chk({16'b0, tx_log[1]}, 32'd0, "R3 idle slot1");
    endtask

    task automatic t_align();
        int f0;
        while (p != 5) tick_wait();
        f0 = 2 * (frame_no + 1);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        wait_logged(f0 + 5);
        chk({16'b0, tx_log[f0]}, 32'd0, "R4 fill slot0");
        chk({16'b0, tx_log[f0 + 1]}, 32'd0, "R4 fill slot1");
        chk({16'b0, tx_log[f0 + 2]}, {16'b0, pair_val(0)[15:0]}, "R5 low half slot0");
        chk({16'b0, tx_log[f0 + 3]}, {16'b0, pair_val(0)[31:16]}, "R5 high half slot1");
        chk({16'b0, tx_log[f0 + 4]}, {16'b0, pair_val(1)[15:0]}, "R2 msb-first word");
        chk({16'b0, tx_log[f0 + 5]}, {16'b0, pair_val(1)[31:16]}, "R5 second pair high");
        while (rx_n < 2) tick_wait();
        chk(rx_log[0], {in_word(f0 + 3), in_word(f0 + 2)}, "R6 first delivered pair");
        chk(rx_log[1], {in_word(f0 + 5), in_word(f0 + 4)}, "R6 second pair");
    endtask

    task automatic t_underrun();
        int f, nres;
        chk({31'b0, underrun}, 32'd0, "R7 no underrun yet");
        feed_en = 0;
        tick_wait();
        while (!tx_room) tick_wait();
        f = frame_no;
        while (!(frame_no == f + 1 && p >= 1)) tick_wait();
        chk({31'b0, underrun}, 32'd1, "R7 underrun set");
        nres = feed_n;
        feed_en = 1;
        wait_logged(2 * f + 5);
        chk({16'b0, tx_log[2 * f + 2]}, 32'd0, "R7 zero slot0");
        chk({16'b0, tx_log[2 * f + 3]}, 32'd0, "R7 zero slot1");
        chk({16'b0, tx_log[2 * f + 4]}, {16'b0, pair_val(nres)[15:0]}, "R7 resume low");
        chk({16'b0, tx_log[2 * f + 5]}, {16'b0, pair_val(nres)[31:16]}, "R7 resume high");
        chk({31'b0, underrun}, 32'd1, "R7 underrun sticky");
    endtask

    task automatic t_coincide();
        int f, n0;
        take_mode = 0;
        tick_wait();
        while (!rx_valid) tick_wait();
        n0 = rx_n;
        coinc_done = 0;
        take_mode = 2;
        while (!coinc_done) tick_wait();
        f = frame_no;
        repeat (4) tick_wait();
        chk(rx_log[n0], {in_word(2 * f - 1), in_word(2 * f - 2)}, "R9 old pair taken");
        chk({31'b0, rx_valid}, 32'd1, "R9 new pair valid");
        chk(rx_pair, {in_word(2 * f + 1), in_word(2 * f)}, "R9 new pair value");
        chk({31'b0, overrun}, 32'd0, "R9 no overrun");
        take_mode = 1;
        repeat (6) tick_wait();
    endtask

    task automatic t_overrun();
        int f, guard;
        take_mode = 0;
        guard = 0;
        tick_wait();
        while (!overrun && guard < 1000) begin
            tick_wait();
            guard++;
        end
        f = frame_no;
        chk({31'b0, overrun}, 32'd1, "R8 overrun set");
        chk(rx_pair, {in_word(2 * f + 1), in_word(2 * f)}, "R8 pair replaced");
        take_mode = 1;
        repeat (200) tick_wait();
        chk({31'b0, overrun}, 32'd1, "R8 overrun sticky");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        run_serial = 1;
        t_idle();
        t_align();
        t_underrun();
        t_coincide();
        t_overrun();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule